// File: doc/BRIEF.md
# Chip-Rate Phase Accumulator NCO

This block is a numerically controlled oscillator that paces a spreading-code generator. It keeps a 32-bit phase accumulator. On every valid input sample it adds a programmable frequency word to the accumulator. When the running sum reaches a decimal modulus of 100,000,000, it takes the modulus off and emits a chip-advance strobe. The code generator downstream steps one chip per strobe. Over a long run, the average number of strobes per sample is therefore the frequency word divided by 100,000,000.

A sync input realigns the oscillator by loading the accumulator with a programmable phase word. The frequency and phase words are held on static inputs that a register interface outside this block drives. The accumulator value is also brought out, so that downstream logic can use the fractional chip phase.

Top module: `chip_nco`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the accumulator becomes 0 and `chip_adv_o` becomes 0, whatever the other inputs are.
- R2: With `sync_i` high at an edge, `phase_o` takes the value of `phase_word_i` and `chip_adv_o` is 0 after that edge.
- R3: When `sync_i` and `sample_vld_i` are both high at the same edge, the load of R2 takes place and no frequency word is added.
- R4: With `sample_vld_i` high and `sync_i` low, let S = `phase_o` + `freq_word_i`. If S is below 100,000,000, `phase_o` becomes S and `chip_adv_o` is 0.
- R5: Under the conditions of R4, if S is 100,000,000 or more (equality included), `phase_o` becomes S − 100,000,000 and `chip_adv_o` is 1 for the cycle after that edge.
- R6: S is formed with 33 bits, so a sum above 2^32−1 is neither truncated nor wrapped before the compare. For example, 99,999,999 + 4,294,967,295 gives 4,294,967,294 with a strobe.
- R7: With `sync_i` and `sample_vld_i` both low, `phase_o` keeps its value and `chip_adv_o` is 0.
- R8: `chip_adv_o` is high only in a cycle that follows a wrapping sample. A run of N samples with frequency F, starting from phase 0, produces floor(N·F / 100,000,000) strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| sync_i | input | 1 | Load the accumulator with the phase word |
| sample_vld_i | input | 1 | A sample is present; add the frequency word |
| freq_word_i | input | 32 | Phase increment per sample |
| phase_word_i | input | 32 | Value loaded on sync |
| chip_adv_o | output | 1 | One-cycle strobe per modulus wrap |
| phase_o | output | 32 | Current accumulator value |

## Verification
Every result of this block is due exactly one clock edge after the inputs that cause it. The loaded phase, the accumulated sum, the wrapped remainder and the chip-advance strobe all appear together after that edge. The bench applies inputs on the falling edge and at the same moment queues the expected accumulator value and strobe. The monitor takes one item from the queue shortly after each rising edge and compares it. Each expectation is therefore checked in exactly the cycle it falls due, never earlier or later. The long run at a fixed frequency also counts the strobes it sees against the floor-division total.

// File: rtl/nco_pkg.sv
// Package: shared constants of the chip-rate NCO.
// Assumes: users override widths/modulus through module parameters,
// defaults are taken from here.
package nco_pkg;
    parameter int unsigned     NCO_W       = 32;
    parameter longint unsigned NCO_MODULUS = 64'd100_000_000;
endpackage

// File: rtl/nco_wrap_adder.sv
// Module: nco_wrap_adder
// Adds the increment to the accumulator with one extra carry bit and
// takes the modulus off once when the sum reaches it.
// Assumes: accumulator and increment are normally below the modulus;
// otherwise only one subtraction per step is done.
module nco_wrap_adder #(
    parameter int unsigned     ACC_W   = nco_pkg::NCO_W,
    parameter longint unsigned MODULUS = nco_pkg::NCO_MODULUS
) (
    input  logic [ACC_W-1:0] acc_i,
    input  logic [ACC_W-1:0] inc_i,
    output logic [ACC_W-1:0] next_o,
    output logic             wrap_o
);
    localparam int unsigned     SUM_W = ACC_W + 1;
    localparam logic [SUM_W-1:0] MOD_V = SUM_W'(MODULUS);

    logic [SUM_W-1:0] sum_w;
    logic [SUM_W-1:0] diff_w;
    logic [SUM_W-1:0] pick_w;
    logic             unused_top;

    // Wide sum, compare and conditional subtract.
    always_comb begin
        sum_w  = {1'b0, acc_i} + {1'b0, inc_i};
        diff_w = sum_w - MOD_V;
        wrap_o = (sum_w >= MOD_V);
        pick_w = wrap_o ? diff_w : sum_w;
        next_o = pick_w[ACC_W-1:0];
    end

    assign unused_top = pick_w[SUM_W-1];
endmodule

// File: rtl/nco_phase_reg.sv
// Module: nco_phase_reg
// Holds the phase accumulator. Priority: reset, sync load, sample step,
// hold.
// Assumes: synchronous active-low reset.
module nco_phase_reg #(
    parameter int unsigned ACC_W = nco_pkg::NCO_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_i,
    input  logic             step_i,
    input  logic [ACC_W-1:0] load_val_i,
    input  logic [ACC_W-1:0] step_val_i,
    output logic [ACC_W-1:0] acc_o
);
    // Accumulator update with sync taking precedence over stepping.
    always_ff @(posedge clk) begin
        if (!rst_n)      acc_o <= '0;
        else if (sync_i) acc_o <= load_val_i;
        else if (step_i) acc_o <= step_val_i;
    end
endmodule

// File: rtl/nco_strobe.sv
// Module: nco_strobe
// Registers the chip-advance strobe on the same edge as the wrapped
// accumulator value, so both are seen together.
// Assumes: the wrap flag is combinational from the current accumulator.
module nco_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_i,
    input  logic step_i,
    input  logic wrap_i,
    output logic adv_o
);
    // One pulse per wrapping sample; sync suppresses it.
    always_ff @(posedge clk) begin
        if (!rst_n) adv_o <= 1'b0;
        else        adv_o <= step_i && !sync_i && wrap_i;
    end
endmodule

// File: rtl/chip_nco.sv
// Module: chip_nco (top)
// Chip-rate phase accumulator: sync loads the phase word. Each valid
// sample adds the frequency word, modulo the decimal modulus, and every
// wrap issues a one-cycle chip-advance strobe.
// Assumes: freq and phase words are static or change between samples.
module chip_nco #(
    parameter int unsigned     ACC_W   = nco_pkg::NCO_W,
    parameter longint unsigned MODULUS = nco_pkg::NCO_MODULUS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_i,
    input  logic             sample_vld_i,
    input  logic [ACC_W-1:0] freq_word_i,
    input  logic [ACC_W-1:0] phase_word_i,
    output logic             chip_adv_o,
    output logic [ACC_W-1:0] phase_o
);
    logic [ACC_W-1:0] next_w;
    logic             wrap_w;

    nco_wrap_adder #(.ACC_W(ACC_W), .MODULUS(MODULUS)) u_add (
        .acc_i (phase_o),
        .inc_i (freq_word_i),
        .next_o(next_w),
        .wrap_o(wrap_w)
    );

    nco_phase_reg #(.ACC_W(ACC_W)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_i    (sync_i),
        .step_i    (sample_vld_i),
        .load_val_i(phase_word_i),
        .step_val_i(next_w),
        .acc_o     (phase_o)
    );

    nco_strobe u_stb (
        .clk   (clk),
        .rst_n (rst_n),
        .sync_i(sync_i),
        .step_i(sample_vld_i),
        .wrap_i(wrap_w),
        .adv_o (chip_adv_o)
    );
endmodule

// File: rtl/chip_nco_chk.sv
// Module: chip_nco_chk
// Assertion checker for chip_nco, relating port values across one edge.
// Assumes: reset is asserted at time zero.
module chip_nco_chk #(
    parameter int unsigned     ACC_W   = nco_pkg::NCO_W,
    parameter longint unsigned MODULUS = nco_pkg::NCO_MODULUS
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sync_i,
    input logic             sample_vld_i,
    input logic [ACC_W-1:0] freq_word_i,
    input logic [ACC_W-1:0] phase_word_i,
    input logic             chip_adv_o,
    input logic [ACC_W-1:0] phase_o
);
    localparam logic [ACC_W:0] MOD_V = (ACC_W+1)'(MODULUS);

    logic [ACC_W:0] sum_c;
    // Reference sum for the checker.
    always_comb sum_c = {1'b0, phase_o} + {1'b0, freq_word_i};

    // R2 and R3: sync loads the phase word, with no strobe.
    p_sync_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sync_i |=> (phase_o == $past(phase_word_i)) && !chip_adv_o);

    // R4: a non-wrapping step adds the frequency word.
    p_accum_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_vld_i && !sync_i && sum_c < MOD_V)
        |=> ({1'b0, phase_o} == $past(sum_c)) && !chip_adv_o);

    // R5 and R6: a wrapping step subtracts the modulus and strobes.
    p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_vld_i && !sync_i && sum_c >= MOD_V)
        |=> ({1'b0, phase_o} == $past(sum_c) - MOD_V) && chip_adv_o);

    // R7: idle cycles hold the phase.
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample_vld_i && !sync_i) |=> $stable(phase_o) && !chip_adv_o);

    // R8: a strobe follows only a sample step without sync.
    p_strobe_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        chip_adv_o |-> $past(sample_vld_i && !sync_i));
endmodule

bind chip_nco chip_nco_chk #(.ACC_W(ACC_W), .MODULUS(MODULUS)) u_chk (.*);

// File: tb/chip_nco_test.sv
module chip_nco_test;
    localparam int CLK_PERIOD = 10;
    localparam longint MODV   = 100_000_000;

    typedef struct {
        logic [31:0] acc;
        logic        adv;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync_i = 1'b0;
    logic        sample_vld_i = 1'b0;
    logic [31:0] freq_word_i = '0;
    logic [31:0] phase_word_i = '0;
    logic        chip_adv_o;
    logic [31:0] phase_o;

    exp_t   sb_q[$];
    int     n_cmp = 0;
    int     n_bad = 0;
    int     n_adv = 0;
    longint m_acc = 0;
    bit     done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    chip_nco uut (
        .clk(clk), .rst_n(rst_n), .sync_i(sync_i),
        .sample_vld_i(sample_vld_i), .freq_word_i(freq_word_i),
        .phase_word_i(phase_word_i), .chip_adv_o(chip_adv_o),
        .phase_o(phase_o)
    );

    // Driver: apply one cycle of stimulus and queue the expected result.
    task automatic drive(input bit r, input bit s, input bit v,
                         input logic [31:0] f, input logic [31:0] p,
                         input string tag);
        exp_t e;
        bit   adv;
        @(negedge clk);
        rst_n = r; sync_i = s; sample_vld_i = v;
        freq_word_i = f; phase_word_i = p;
        adv = 0;
        if (!r) m_acc = 0;
        else if (s) m_acc = p;
        else if (v) begin
            m_acc = m_acc + longint'(f);
            if (m_acc >= MODV) begin
                m_acc = m_acc - MODV;
                adv = 1;
            end
        end
        e.acc = m_acc[31:0];
        e.adv = adv;
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    // Monitor: one expected item is due right after each rising edge.
    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_cmp++;
            if (phase_o !== e.acc || chip_adv_o !== e.adv) begin
                n_bad++;
                $display("FAIL %s: phase=%0d adv=%0b expected phase=%0d adv=%0b",
                         e.tag, phase_o, chip_adv_o, e.acc, e.adv);
            end
            if (chip_adv_o === 1'b1) n_adv++;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // Test sequence.
    initial begin
        int adv_before;
        // R1: reset state, with the other inputs active.
        drive(0, 0, 0, 32'd0, 32'd0, "R1 reset");
        drive(0, 1, 1, 32'd5, 32'd7, "R1 reset dominates");
        // R2: sync load.
        drive(1, 1, 0, 32'd0, 32'd12345, "R2 sync load");
        // R7: idle hold.
        drive(1, 0, 0, 32'd999, 32'd1, "R7 idle hold");
        drive(1, 0, 0, 32'd999, 32'd1, "R7 idle hold 2");
        // R4: plain accumulate.
        drive(1, 0, 1, 32'd1000, 32'd0, "R4 accumulate");
        drive(1, 0, 1, 32'd30_000_000, 32'd0, "R4 accumulate large");
        // R3: sync over valid.
        drive(1, 1, 1, 32'd50_000_000, 32'd99_999_999, "R3 sync priority");
        // R4: sum just below the modulus (acc 0 + 99,999,999).
        drive(1, 1, 0, 32'd0, 32'd0, "R2 sync zero");
        drive(1, 0, 1, 32'd99_999_999, 32'd0, "R4 just below modulus");
        // R5: exact equality wraps to 0 (99,999,999 + 1).
        drive(1, 0, 1, 32'd1, 32'd0, "R5 equality wraps");
        drive(1, 0, 0, 32'd1, 32'd0, "R8 strobe single cycle");
        // R5: wrap with a remainder.
        drive(1, 1, 0, 32'd0, 32'd90_000_000, "R2 sync preload");
        drive(1, 0, 1, 32'd25_000_000, 32'd0, "R5 wrap remainder");
        // R6: sum beyond 32 bits.
        drive(1, 1, 0, 32'd0, 32'd99_999_999, "R2 sync preload 2");
        drive(1, 0, 1, 32'hFFFF_FFFF, 32'd0, "R6 no lost carry");
        // R1: reset in mid-run.
        drive(0, 0, 1, 32'd5, 32'd0, "R1 mid-run reset");
        // R8: long run, F = 7,000,000 for 100 samples with gaps.
        adv_before = n_adv;
        for (int i = 0; i < 100; i++) begin
            drive(1, 0, 1, 32'd7_000_000, 32'd0, "R8 long run");
            if (i % 3 == 0) drive(1, 0, 0, 32'd7_000_000, 32'd0, "R7 gap in run");
        end
        drive(1, 0, 0, 32'd0, 32'd0, "R7 final idle");
        @(negedge clk);
        @(negedge clk);
        n_cmp++;
        if (n_adv - adv_before != 7) begin
            n_bad++;
            $display("FAIL R8 strobe count: got %0d expected 7", n_adv - adv_before);
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule